// File: doc/BRIEF.md
# Write-Once Store with Deferred Reads

This block is a small data store where every word can be written exactly once and carries a presence state: empty, filled, or holding readers that wait for it. A read names a word and carries a continuation tag. If the word is filled, the block returns the datum together with that tag. If the word is still empty, the block does not stall. It parks the tag in a linked chain that belongs to that word and moves on to the next request.

When the single legal write to a word with parked readers arrives, the block stores the datum. It then walks the chain from oldest to newest and issues one response per parked tag, each carrying the new datum. The chains are built from a shared pool of link entries, and the walk returns each entry to the pool. A second write to a filled word leaves the word as it is and raises a one-cycle error pulse.

Both data interfaces are valid/ready streams. A request is taken on a cycle with `req_valid` and `req_ready` both high. `req_ready` is held low in three cases: while a chain is being replayed, while a response waits for `rsp_ready`, and for read requests while every link entry is in use. A response offered with `rsp_valid` stays on the port with the same data and tag until `rsp_ready` is high.

Top module: `istore_mem`

## Requirements
- R1: After reset every word is empty, `rsp_valid` and `err_write` are low, and `req_ready` is high while no request is presented.
- R2: A read accepted on a filled word drives `rsp_valid` high on the next cycle, with the stored datum on `rsp_data` and the request tag on `rsp_tag`.
- R3: A read accepted on an empty or waiting word produces no response. Its tag is parked at the end of that word's chain.
- R4: A write accepted on a waiting word stores the datum and emits one response per parked tag. The responses come oldest first, at one per cycle while `rsp_ready` is high, and each carries the written datum. `req_ready` stays low from the cycle after the write until the last of these responses has been loaded.
- R5: A write accepted on a filled word drives `err_write` high for exactly the next cycle. The stored datum stays unchanged, and later reads return the first value.
- R6: A write accepted on an empty word fills it without producing a response. Later reads return the datum.
- R7: While every link entry holds a parked tag, `req_ready` is low for read requests. Write requests are still accepted.
- R8: While `rsp_valid` is high and `rsp_ready` is low, `rsp_data` and `rsp_tag` hold their values and `req_ready` is low.
- R9: Link entries released by a replay are available again for new parked reads.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Request can be taken this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | AW | Word index |
| req_data | input | DW | Datum for a write |
| req_tag | input | TW | Continuation tag for a read |
| rsp_valid | output | 1 | Response offered |
| rsp_ready | input | 1 | Consumer takes the response |
| rsp_data | output | DW | Datum returned |
| rsp_tag | output | TW | Continuation tag of the reader |
| err_write | output | 1 | One-cycle pulse after a write to a filled word |

## Verification
The hardest state to reach from the ports is a completely full link pool whose replay is then stalled by a consumer that withholds `rsp_ready`. Reaching it takes many reads to the same empty word, with no write to that word in between. A directed sequence fills all entries on one word. It checks that a further read is refused and that a write is still taken, then lets the chain drain and reuses the freed entries. Random rounds restrict addresses to a few words, throttle `rsp_ready` at random, and force a write whenever the reference model counts a full pool, so long chains and stalled replays occur often.

// File: rtl/istore_pkg.sv
package istore_pkg;
  typedef enum logic [1:0] {
    W_EMPTY   = 2'd0,
    W_FILLED  = 2'd1,
    W_WAITING = 2'd2
  } wstate_e;
endpackage

// File: rtl/istore_links.sv
module istore_links #(
  parameter int LINKS = 8,
  parameter int TW    = 4,
  localparam int IW   = (LINKS > 1) ? $clog2(LINKS) : 1,
  localparam int LW   = IW + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          alloc_en,
  input  logic [TW-1:0] alloc_tag,
  output logic [LW-1:0] alloc_idx,
  output logic          has_free,
  input  logic          chain_en,
  input  logic [LW-1:0] chain_from,
  input  logic [LW-1:0] chain_to,
  input  logic          free_en,
  input  logic [LW-1:0] free_idx,
  input  logic [LW-1:0] look_idx,
  output logic [TW-1:0] look_tag,
  output logic [LW-1:0] look_next
);
  localparam logic [LW-1:0] NIL = {LW{1'b1}};

  logic [LINKS-1:0] busy_q;
  logic [TW-1:0]    tag_q  [LINKS];
  logic [LW-1:0]    next_q [LINKS];

  always_comb begin
    alloc_idx = NIL;
    for (int i = LINKS - 1; i >= 0; i--) begin
      if (!busy_q[i]) alloc_idx = LW'(i);
    end
  end

  assign has_free  = ~&busy_q;
  assign look_tag  = tag_q[look_idx[IW-1:0]];
  assign look_next = next_q[look_idx[IW-1:0]];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q <= '0;
    end else begin
      if (alloc_en) busy_q[alloc_idx[IW-1:0]] <= 1'b1;
      if (free_en)  busy_q[free_idx[IW-1:0]]  <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (alloc_en) begin
      tag_q[alloc_idx[IW-1:0]]  <= alloc_tag;
      next_q[alloc_idx[IW-1:0]] <= NIL;
    end
    if (chain_en) next_q[chain_from[IW-1:0]] <= chain_to;
  end

  assert_alloc_room_R7: assert property (@(posedge clk) disable iff (!rst_n)
    alloc_en |-> has_free);
  assert_free_live_R9: assert property (@(posedge clk) disable iff (!rst_n)
    free_en |-> busy_q[free_idx[IW-1:0]]);
  assert_chain_tail_R3: assert property (@(posedge clk) disable iff (!rst_n)
    chain_en |-> (busy_q[chain_from[IW-1:0]] && next_q[chain_from[IW-1:0]] == NIL));
endmodule

// File: rtl/istore_words.sv
module istore_words
  import istore_pkg::*;
#(
  parameter int AW = 4,
  parameter int DW = 16,
  parameter int LW = 4,
  localparam int DEPTH = 1 << AW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] rd_addr,
  output wstate_e       rd_state,
  output logic [DW-1:0] rd_data,
  output logic [LW-1:0] rd_head,
  output logic [LW-1:0] rd_tail,
  input  logic [AW-1:0] wr_addr,
  input  logic          store_en,
  input  logic [DW-1:0] store_data,
  input  logic          park_first_en,
  input  logic          park_more_en,
  input  logic [LW-1:0] park_ptr
);
  wstate_e       st_q   [DEPTH];
  logic [DW-1:0] data_q [DEPTH];
  logic [LW-1:0] head_q [DEPTH];
  logic [LW-1:0] tail_q [DEPTH];

  assign rd_state = st_q[rd_addr];
  assign rd_data  = data_q[rd_addr];
  assign rd_head  = head_q[rd_addr];
  assign rd_tail  = tail_q[rd_addr];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) st_q[i] <= W_EMPTY;
    end else if (store_en) begin
      st_q[wr_addr] <= W_FILLED;
    end else if (park_first_en) begin
      st_q[wr_addr] <= W_WAITING;
    end
  end

  always_ff @(posedge clk) begin
    if (store_en) data_q[wr_addr] <= store_data;
    if (park_first_en) begin
      head_q[wr_addr] <= park_ptr;
      tail_q[wr_addr] <= park_ptr;
    end
    if (park_more_en) tail_q[wr_addr] <= park_ptr;
  end

  assert_write_once_R5: assert property (@(posedge clk) disable iff (!rst_n)
    store_en |-> st_q[wr_addr] != W_FILLED);
  assert_park_state_R3: assert property (@(posedge clk) disable iff (!rst_n)
    park_more_en |-> st_q[wr_addr] == W_WAITING);
  assert_one_update_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({store_en, park_first_en, park_more_en}));
endmodule

// File: rtl/istore_mem.sv
module istore_mem
  import istore_pkg::*;
#(
  parameter int AW    = 4,
  parameter int DW    = 16,
  parameter int TW    = 4,
  parameter int LINKS = 8,
  localparam int IW   = (LINKS > 1) ? $clog2(LINKS) : 1,
  localparam int LW   = IW + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic          req_write,
  input  logic [AW-1:0] req_addr,
  input  logic [DW-1:0] req_data,
  input  logic [TW-1:0] req_tag,
  output logic          rsp_valid,
  input  logic          rsp_ready,
  output logic [DW-1:0] rsp_data,
  output logic [TW-1:0] rsp_tag,
  output logic          err_write
);
  wstate_e       w_state;
  logic [DW-1:0] w_data;
  logic [LW-1:0] w_head, w_tail;
  logic [LW-1:0] new_idx, look_next;
  logic [TW-1:0] look_tag;
  logic          has_free;

  logic          draining_q;
  logic [LW-1:0] drain_ptr_q;
  logic [DW-1:0] drain_data_q;
  logic          rsp_valid_q, err_q;
  logic [DW-1:0] rsp_data_q;
  logic [TW-1:0] rsp_tag_q;

  logic slot_free, accept, rd_hit, rd_first, rd_more, wr_fill, wr_dup, drain_step;

  assign slot_free  = !rsp_valid_q || rsp_ready;
  assign req_ready  = !draining_q && slot_free && (req_write || has_free);
  assign accept     = req_valid && req_ready;
  assign rd_hit     = accept && !req_write && w_state == W_FILLED;
  assign rd_first   = accept && !req_write && w_state == W_EMPTY;
  assign rd_more    = accept && !req_write && w_state == W_WAITING;
  assign wr_fill    = accept && req_write && w_state != W_FILLED;
  assign wr_dup     = accept && req_write && w_state == W_FILLED;
  assign drain_step = draining_q && slot_free;

  istore_words #(.AW(AW), .DW(DW), .LW(LW)) words_i (
    .clk, .rst_n,
    .rd_addr(req_addr), .rd_state(w_state), .rd_data(w_data),
    .rd_head(w_head), .rd_tail(w_tail),
    .wr_addr(req_addr), .store_en(wr_fill), .store_data(req_data),
    .park_first_en(rd_first), .park_more_en(rd_more), .park_ptr(new_idx)
  );

  istore_links #(.LINKS(LINKS), .TW(TW)) links_i (
    .clk, .rst_n,
    .alloc_en(rd_first || rd_more), .alloc_tag(req_tag),
    .alloc_idx(new_idx), .has_free(has_free),
    .chain_en(rd_more), .chain_from(w_tail), .chain_to(new_idx),
    .free_en(drain_step), .free_idx(drain_ptr_q),
    .look_idx(drain_ptr_q), .look_tag(look_tag), .look_next(look_next)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      draining_q  <= 1'b0;
      drain_ptr_q <= '0;
    end else if (wr_fill && w_state == W_WAITING) begin
      draining_q  <= 1'b1;
      drain_ptr_q <= w_head;
    end else if (drain_step) begin
      drain_ptr_q <= look_next;
      if (look_next[LW-1]) draining_q <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (wr_fill) drain_data_q <= req_data;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid_q <= 1'b0;
      rsp_data_q  <= '0;
      rsp_tag_q   <= '0;
      err_q       <= 1'b0;
    end else begin
      err_q <= wr_dup;
      if (rd_hit) begin
        rsp_valid_q <= 1'b1;
        rsp_data_q  <= w_data;
        rsp_tag_q   <= req_tag;
      end else if (drain_step) begin
        rsp_valid_q <= 1'b1;
        rsp_data_q  <= drain_data_q;
        rsp_tag_q   <= look_tag;
      end else if (rsp_ready) begin
        rsp_valid_q <= 1'b0;
      end
    end
  end

  assign rsp_valid = rsp_valid_q;
  assign rsp_data  = rsp_data_q;
  assign rsp_tag   = rsp_tag_q;
  assign err_write = err_q;

  assert_rsp_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_data) && $stable(rsp_tag)));
  assert_stall_blocks_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |-> !req_ready);
  assert_replay_blocks_R4: assert property (@(posedge clk) disable iff (!rst_n)
    draining_q |-> !req_ready);
  assert_hit_answers_R2: assert property (@(posedge clk) disable iff (!rst_n)
    rd_hit |=> (rsp_valid && rsp_tag == $past(req_tag)));
  assert_err_cause_R5: assert property (@(posedge clk) disable iff (!rst_n)
    err_write |-> $past(req_valid && req_write));
endmodule

// File: tb/istore_mem_tb_top.sv
`timescale 1ns/1ps
module istore_mem_tb_top;
  localparam int AW = 4, DW = 16, TW = 4, LINKS = 8;
  localparam int DEPTH = 1 << AW;
  localparam int WATCHDOG = 20000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0, req_write = 1'b0, rsp_ready = 1'b1;
  logic [AW-1:0] req_addr = '0;
  logic [DW-1:0] req_data = '0;
  logic [TW-1:0] req_tag = '0;
  logic req_ready, rsp_valid, err_write;
  logic [DW-1:0] rsp_data;
  logic [TW-1:0] rsp_tag;

  always #2 clk = ~clk;

  istore_mem #(.AW(AW), .DW(DW), .TW(TW), .LINKS(LINKS)) dut_i (
    .clk, .rst_n, .req_valid, .req_ready, .req_write, .req_addr, .req_data,
    .req_tag, .rsp_valid, .rsp_ready, .rsp_data, .rsp_tag, .err_write
  );

  int n_chk = 0, n_err = 0, cyc = 0;
  bit rnd_mode = 1'b0;
  bit last_fire;
  int mst [DEPTH];
  logic [DW-1:0] mdat [DEPTH];
  logic [TW-1:0] mq [DEPTH][LINKS];
  int mcnt [DEPTH];
  int used;
  logic [DW-1:0] fd [256];
  logic [TW-1:0] ft [256];
  int fh, fl;
  bit exp_err;

  task automatic chk(input bit ok, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s: actual=%0h expected=%0h (cycle %0d)", what, act, exp, cyc);
    end
  endtask

  function automatic void push_rsp(input logic [DW-1:0] d, input logic [TW-1:0] t);
    fd[fl % 256] = d;
    ft[fl % 256] = t;
    fl++;
  endfunction

  function automatic void model_accept();
    int a;
    a = int'(req_addr);
    if (!req_write) begin
      if (mst[a] == 1) push_rsp(mdat[a], req_tag);
      else begin
        mq[a][mcnt[a]] = req_tag;
        mcnt[a]++;
        used++;
        mst[a] = 2;
      end
    end else if (mst[a] == 1) begin
      exp_err = 1'b1;
    end else begin
      for (int k = 0; k < mcnt[a]; k++) push_rsp(req_data, mq[a][k]);
      used -= mcnt[a];
      mcnt[a] = 0;
      mdat[a] = req_data;
      mst[a] = 1;
    end
  endfunction

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  endtask

  task automatic step();
    bit fr, fs;
    #1;
    cyc++;
    fr = req_valid && req_ready;
    fs = rsp_valid && rsp_ready;
    chk(err_write == exp_err, "R5 err_write pulse", 32'(err_write), 32'(exp_err));
    if (fs) begin
      if (fh == fl) chk(1'b0, "R3 response with none expected", 32'(rsp_tag), 32'hFFFF);
      else begin
        chk(rsp_data == fd[fh % 256], "R4 response data", 32'(rsp_data), 32'(fd[fh % 256]));
        chk(rsp_tag == ft[fh % 256], "R4 response tag order", 32'(rsp_tag), 32'(ft[fh % 256]));
        fh++;
      end
    end
    if (used >= LINKS && req_valid && !req_write)
      chk(!req_ready, "R7 read refused with full pool", 32'(req_ready), 32'd0);
    exp_err = 1'b0;
    last_fire = fr;
    if (fr) model_accept();
    if (cyc > WATCHDOG) begin
      chk(1'b0, "watchdog expired", 32'(cyc), 32'(WATCHDOG));
      finish_run();
    end
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic send(input bit w, input int a, input logic [DW-1:0] d, input logic [TW-1:0] t);
    req_valid = 1'b1;
    req_write = w;
    req_addr  = AW'(a);
    req_data  = d;
    req_tag   = t;
    do begin
      if (rnd_mode) rsp_ready = ($urandom % 4) != 0;
      step();
    end while (!last_fire);
    req_valid = 1'b0;
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    req_valid = 1'b0;
    rsp_ready = 1'b1;
    repeat (3) @(negedge clk);
    for (int i = 0; i < DEPTH; i++) begin
      mst[i] = 0;
      mcnt[i] = 0;
    end
    used = 0;
    fh = 0;
    fl = 0;
    exp_err = 1'b0;
    rst_n = 1'b1;
    @(negedge clk);
    #1;
    chk(req_ready == 1'b1, "R1 ready after reset", 32'(req_ready), 32'd1);
    chk(rsp_valid == 1'b0, "R1 no response after reset", 32'(rsp_valid), 32'd0);
    chk(err_write == 1'b0, "R1 no error after reset", 32'(err_write), 32'd0);
    @(negedge clk);
  endtask

  task automatic drain_all();
    req_valid = 1'b0;
    rsp_ready = 1'b1;
    for (int i = 0; i < 40 && fh != fl; i++) step();
    step();
    chk(fh == fl, "R4 all expected responses delivered", 32'(fl - fh), 32'd0);
  endtask

  initial begin
    int seed_init;
    seed_init = $urandom(32'h1D5EED);
    do_reset();

    // R6: write to empty word gives no response
    send(1'b1, 3, 16'hA5A5, 4'd0);
    chk(rsp_valid == 1'b0, "R6 no response on fill", 32'(rsp_valid), 32'd0);
    // R2: read of filled word answers next cycle
    send(1'b0, 3, 16'h0, 4'd5);
    chk(rsp_valid == 1'b1, "R2 hit response valid", 32'(rsp_valid), 32'd1);
    chk(rsp_data == 16'hA5A5, "R2 hit data", 32'(rsp_data), 32'hA5A5);
    chk(rsp_tag == 4'd5, "R2 hit tag", 32'(rsp_tag), 32'd5);
    // R3: reads to empty word are parked
    for (int t = 1; t <= 3; t++) begin
      send(1'b0, 7, 16'h0, TW'(t));
      chk(rsp_valid == 1'b0, "R3 parked read silent", 32'(rsp_valid), 32'd0);
    end
    // R4: replay in order, one per cycle, ready low throughout
    send(1'b1, 7, 16'h1234, 4'd0);
    for (int k = 0; k < 3; k++) begin
      chk(req_ready == 1'b0, "R4 ready low during replay", 32'(req_ready), 32'd0);
      if (k > 0) chk(rsp_tag == TW'(k), "R4 replay tag order", 32'(rsp_tag), 32'(k));
      step();
    end
    chk(rsp_valid && rsp_tag == 4'd3 && rsp_data == 16'h1234, "R4 last replay",
        32'({rsp_tag, rsp_data}), 32'({4'd3, 16'h1234}));
    chk(req_ready == 1'b1, "R4 ready after replay", 32'(req_ready), 32'd1);
    // R5: second write flagged, value kept
    send(1'b1, 3, 16'hBEEF, 4'd0);
    chk(err_write == 1'b1, "R5 error pulse", 32'(err_write), 32'd1);
    send(1'b0, 3, 16'h0, 4'd9);
    chk(rsp_data == 16'hA5A5, "R5 datum unchanged", 32'(rsp_data), 32'hA5A5);
    // R7: fill the pool on one word
    for (int t = 0; t < LINKS; t++) send(1'b0, 9, 16'h0, TW'(t));
    req_valid = 1'b1; req_write = 1'b0; req_addr = 4'd10; req_tag = 4'hF;
    #1;
    chk(req_ready == 1'b0, "R7 read refused", 32'(req_ready), 32'd0);
    step();
    step();
    send(1'b1, 9, 16'h0F0F, 4'd0);
    chk(last_fire == 1'b1, "R7 write taken with full pool", 32'(last_fire), 32'd1);
    for (int i = 0; i < LINKS + 2; i++) step();
    // R9: freed entries reused
    send(1'b0, 10, 16'h0, 4'hE);
    send(1'b0, 10, 16'h0, 4'hD);
    send(1'b1, 10, 16'h7777, 4'd0);
    drain_all();
    // R8: stalled response holds and blocks requests
    rsp_ready = 1'b0;
    send(1'b0, 3, 16'h0, 4'd4);
    req_valid = 1'b1; req_write = 1'b0; req_addr = 4'd7; req_tag = 4'd6;
    for (int k = 0; k < 3; k++) begin
      #1;
      chk(rsp_valid && rsp_data == 16'hA5A5 && rsp_tag == 4'd4, "R8 response held",
          32'({rsp_tag, rsp_data}), 32'({4'd4, 16'hA5A5}));
      chk(req_ready == 1'b0, "R8 request blocked", 32'(req_ready), 32'd0);
      @(negedge clk);
    end
    rsp_ready = 1'b1;
    send(1'b0, 7, 16'h0, 4'd6);
    drain_all();

    // Random rounds: few addresses, throttled consumer
    rnd_mode = 1'b1;
    for (int r = 0; r < 6; r++) begin
      do_reset();
      for (int n = 0; n < 80; n++) begin
        bit w;
        w = (used >= LINKS) ? 1'b1 : (($urandom % 3) == 0);
        send(w, int'($urandom % 6), DW'($urandom), TW'($urandom));
        if (($urandom % 3) == 0) step();
      end
      drain_all();
    end
    finish_run();
  end
endmodule